// File: doc/BRIEF.md
# Next-PC and Exception Vector Unit

This block holds the program counter of a single-cycle 32-bit core and decides the address it holds after each clock edge. It always shows the current fetch address. It also shows that address plus four, which the core writes to a link register on calls. The address is word aligned, so the register keeps only the upper thirty bits and the two low bits read as zero.

A three-bit source select chooses the next address on every edge. The choices are the sequential successor, a PC-relative branch target, an absolute jump inside the current 256 MiB region, and a register-indirect target. Three fixed entry points serve reset, an illegal opcode and an interrupt. The branch target has its own adder, because the main ALU is busy in the same cycle with the operand comparison that decides the branch. A synchronous reset input takes priority over the source select. The instruction memory and the logic that produces the select are outside this block.

Top module: `npc_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pcOut` becomes 0x80000000 after that edge, whatever the value of `pcSel`.
- R2: `pcPlus4` always equals `pcOut + 4` modulo 2^32, so 0xFFFFFFFC gives 0x00000000.
- R3: With `pcSel` = 0 (sequential), the next `pcOut` is the current `pcPlus4`, and it wraps through zero.
- R4: With `pcSel` = 1 (branch), the next `pcOut` is `pcPlus4` plus `immField` sign-extended from bit 15 and multiplied by four. Negative offsets include 0x8000.
- R5: With `pcSel` = 2 (jump), the next `pcOut` is {`pcPlus4`[31:28], `jumpField`[25:0], 2'b00}. The region bits come from the incremented address.
- R6: With `pcSel` = 3 (indirect), the next `pcOut` is `regValue` with its two low bits forced to zero.
- R7: With `pcSel` = 4, the next `pcOut` is the reset entry 0x80000000.
- R8: With `pcSel` = 5, the next `pcOut` is the illegal-opcode entry 0x80000040.
- R9: With `pcSel` = 6, the next `pcOut` is the interrupt entry 0x80000080.
- R10: `pcSel` = 7 is not a defined source. It behaves as sequential.
- R11: `pcOut`[1:0] is always 0 after the first reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, loads the reset entry point |
| pcSel | input | 3 | Next-address source select (encodings in R3 to R10) |
| jumpField | input | 26 | Word index of an absolute jump |
| immField | input | 16 | Signed word offset of a branch |
| regValue | input | 32 | Register operand used for indirect jumps |
| pcOut | output | 32 | Current program counter |
| pcPlus4 | output | 32 | Current program counter plus four |

## Verification
Reset and a non-sequential source can arrive together. The bench asserts `rst` once while the select asks for the interrupt entry and once while it asks for a jump. In both cases it expects the reset entry. A second overlap is a jump taken from the last word of a region. There, the region bits of the incremented address and of the current address differ. The bench places the counter at 0x8FFFFFFC through an indirect load and then jumps, so it can tell which of the two supplied the upper nibble. Each expected address is computed from the requirement formulas and queued by the driver. A monitor compares the queued value one edge later, together with the link output and the alignment bits.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int ADDR_W    = 32;
  localparam int JUMP_W    = 26;
  localparam int IMM_W     = 16;
  localparam int SEL_W     = 3;
  localparam int VEC_IDX_W = 2;
  localparam int WORD_W    = ADDR_W - 2;
  localparam int REGION_W  = WORD_W - JUMP_W;
  localparam int NUM_VEC_SLOTS = 2 ** VEC_IDX_W;

  localparam logic [ADDR_W-1:0] VEC_BASE   = 32'h8000_0000;
  localparam logic [ADDR_W-1:0] VEC_STRIDE = 32'h0000_0040;

  typedef enum logic [SEL_W-1:0] {
    SRC_SEQ      = 3'd0,
    SRC_BRANCH   = 3'd1,
    SRC_JUMP     = 3'd2,
    SRC_INDIRECT = 3'd3,
    SRC_RESET    = 3'd4,
    SRC_ILLEGAL  = 3'd5,
    SRC_IRQ      = 3'd6,
    SRC_SPARE    = 3'd7
  } pcSrc_e;

  localparam logic [VEC_IDX_W-1:0] VEC_RESET   = 2'd0;
  localparam logic [VEC_IDX_W-1:0] VEC_ILLEGAL = 2'd1;
  localparam logic [VEC_IDX_W-1:0] VEC_IRQ     = 2'd2;

  typedef struct packed {
    logic                 takeBranch;
    logic                 takeJump;
    logic                 takeIndirect;
    logic                 takeVector;
    logic [VEC_IDX_W-1:0] vecIdx;
  } pcStrobe_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic             rst,
  input  logic [SEL_W-1:0] pcSel,
  output pcStrobe_t        strobes
);

  pcSrc_e srcSel;
  assign srcSel = pcSrc_e'(pcSel);

  always_comb begin
    strobes = '0;
    if (rst) begin
      // Reset outranks every select value.
      strobes.takeVector = 1'b1;
      strobes.vecIdx     = VEC_RESET;
    end else begin
      unique case (srcSel)
        SRC_BRANCH:   strobes.takeBranch   = 1'b1;
        SRC_JUMP:     strobes.takeJump     = 1'b1;
        SRC_INDIRECT: strobes.takeIndirect = 1'b1;
        SRC_RESET: begin
          strobes.takeVector = 1'b1;
          strobes.vecIdx     = VEC_RESET;
        end
        SRC_ILLEGAL: begin
          strobes.takeVector = 1'b1;
          strobes.vecIdx     = VEC_ILLEGAL;
        end
        SRC_IRQ: begin
          strobes.takeVector = 1'b1;
          strobes.vecIdx     = VEC_IRQ;
        end
        // Sequential and the spare code both leave every strobe low.
        default: strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
(
  input  logic              clk,
  input  pcStrobe_t         strobes,
  input  logic [JUMP_W-1:0] jumpField,
  input  logic [IMM_W-1:0]  immField,
  input  logic [WORD_W-1:0] indirectWord,
  output logic [WORD_W-1:0] curWord,
  output logic [WORD_W-1:0] seqWord
);

  logic [WORD_W-1:0] pcWord;
  logic [WORD_W-1:0] immExt;
  logic [WORD_W-1:0] branchWord;
  logic [WORD_W-1:0] jumpWord;
  logic [WORD_W-1:0] nextWord;
  logic [WORD_W-1:0] vecTable [NUM_VEC_SLOTS];

  // Fixed entry points, one stride apart from the base.
  for (genvar g = 0; g < NUM_VEC_SLOTS; g++) begin : g_vec
    localparam logic [ADDR_W-1:0] VEC_ADDR = VEC_BASE + ADDR_W'(g) * VEC_STRIDE;
    assign vecTable[g] = VEC_ADDR[ADDR_W-1:2];
  end

  assign seqWord    = pcWord + WORD_W'(1);
  assign immExt     = {{(WORD_W-IMM_W){immField[IMM_W-1]}}, immField};
  assign branchWord = seqWord + immExt;
  assign jumpWord   = {seqWord[WORD_W-1 -: REGION_W], jumpField};

  always_comb begin
    if (strobes.takeVector)        nextWord = vecTable[strobes.vecIdx];
    else if (strobes.takeBranch)   nextWord = branchWord;
    else if (strobes.takeJump)     nextWord = jumpWord;
    else if (strobes.takeIndirect) nextWord = indirectWord;
    else                           nextWord = seqWord;
  end

  always_ff @(posedge clk) begin
    pcWord <= nextWord;
  end

  assign curWord = pcWord;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  pcSel,
  input  logic [JUMP_W-1:0] jumpField,
  input  logic [IMM_W-1:0]  immField,
  input  logic [ADDR_W-1:0] regValue,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] pcPlus4
);

  pcStrobe_t         strobes;
  logic [WORD_W-1:0] curWord;
  logic [WORD_W-1:0] seqWord;
  logic              unusedRegLow;

  // The two low bits of an indirect target are dropped.
  assign unusedRegLow = ^regValue[1:0];

  npc_ctrl ctrl_i (
    .rst     (rst),
    .pcSel   (pcSel),
    .strobes (strobes)
  );

  npc_datapath dp_i (
    .clk          (clk),
    .strobes      (strobes),
    .jumpField    (jumpField),
    .immField     (immField),
    .indirectWord (regValue[ADDR_W-1:2]),
    .curWord      (curWord),
    .seqWord      (seqWord)
  );

  assign pcOut   = {curWord, 2'b00};
  assign pcPlus4 = {seqWord, 2'b00};

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  pcSel,
  input logic [JUMP_W-1:0] jumpField,
  input logic [IMM_W-1:0]  immField,
  input logic [ADDR_W-1:0] regValue,
  input logic [ADDR_W-1:0] pcOut,
  input logic [ADDR_W-1:0] pcPlus4
);

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!started)
    rst |=> pcOut == 32'h8000_0000); // R1

  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst || !started)
    pcPlus4 == pcOut + 32'd4); // R2

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst || !started)
    pcSel == SRC_SEQ |=> pcOut == $past(pcPlus4)); // R3

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst || !started)
    pcSel == SRC_BRANCH |=>
      pcOut == $past(pcPlus4) + {{14{$past(immField[15])}}, $past(immField), 2'b00}); // R4

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst || !started)
    pcSel == SRC_JUMP |=>
      pcOut == {$past(pcPlus4[31:28]), $past(jumpField), 2'b00}); // R5

  AST_INDIRECT_TARGET: assert property (@(posedge clk) disable iff (rst || !started)
    pcSel == SRC_INDIRECT |=> pcOut == {$past(regValue[31:2]), 2'b00}); // R6

  AST_RESET_SELECT: assert property (@(posedge clk) disable iff (rst || !started)
    pcSel == SRC_RESET |=> pcOut == 32'h8000_0000); // R7

  AST_ILLEGAL_ENTRY: assert property (@(posedge clk) disable iff (rst || !started)
    pcSel == SRC_ILLEGAL |=> pcOut == 32'h8000_0040); // R8

  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (rst || !started)
    pcSel == SRC_IRQ |=> pcOut == 32'h8000_0080); // R9

  AST_SPARE_SEQ: assert property (@(posedge clk) disable iff (rst || !started)
    pcSel == SRC_SPARE |=> pcOut == $past(pcPlus4)); // R10

endmodule

bind npc_unit npc_unit_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .pcSel     (pcSel),
  .jumpField (jumpField),
  .immField  (immField),
  .regValue  (regValue),
  .pcOut     (pcOut),
  .pcPlus4   (pcPlus4)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  pcSel = 3'd0;
  logic [25:0] jumpField = '0;
  logic [15:0] immField = '0;
  logic [31:0] regValue = '0;
  logic [31:0] pcOut;
  logic [31:0] pcPlus4;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  logic [31:0] modelPc = 32'h8000_0000;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .pcSel     (pcSel),
    .jumpField (jumpField),
    .immField  (immField),
    .regValue  (regValue),
    .pcOut     (pcOut),
    .pcPlus4   (pcPlus4)
  );

  function automatic logic [31:0] expNext(logic r, logic [2:0] s, logic [15:0] imm,
                                          logic [25:0] jf, logic [31:0] rv, logic [31:0] cur);
    logic [31:0] p4;
    p4 = cur + 32'd4;
    if (r) return 32'h8000_0000;
    case (s)
      3'd1:    return p4 + {{14{imm[15]}}, imm, 2'b00};
      3'd2:    return {p4[31:28], jf, 2'b00};
      3'd3:    return {rv[31:2], 2'b00};
      3'd4:    return 32'h8000_0000;
      3'd5:    return 32'h8000_0040;
      3'd6:    return 32'h8000_0080;
      default: return p4;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected address.
  task automatic step(logic r, logic [2:0] s, logic [15:0] imm, logic [25:0] jf,
                      logic [31:0] rv, string tag);
    @(negedge clk);
    rst = r; pcSel = s; immField = imm; jumpField = jf; regValue = rv;
    modelPc = expNext(r, s, imm, jf, rv, modelPc);
    expQ.push_back(modelPc);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares one queued item after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, pcOut, e);
        check("R2 link", pcPlus4, e + 32'd4);
        check("R11 align", {30'd0, pcOut[1:0]}, 32'd0);
      end
    end
  end

  initial begin
    // R1: reset in the same cycle as an interrupt select
    step(1'b1, 3'd6, 16'h0000, 26'h0, 32'h0, "R1 reset beats irq");
    step(1'b0, 3'd0, 16'h1234, 26'h3FF_FFFF, 32'hDEAD_BEEF, "R3 seq");
    step(1'b0, 3'd0, 16'h0000, 26'h0, 32'h0, "R3 seq again");
    step(1'b0, 3'd1, 16'h0010, 26'h0, 32'h0, "R4 branch forward");
    step(1'b0, 3'd1, 16'hFFFF, 26'h0, 32'h0, "R4 branch back");
    step(1'b0, 3'd3, 16'h0, 26'h0, 32'h1234_567B, "R6 indirect low bits cleared");
    step(1'b0, 3'd2, 16'h0, 26'h3FF_FFFF, 32'h0, "R5 jump");
    step(1'b0, 3'd0, 16'h0, 26'h0, 32'h0, "R3 seq region cross");
    step(1'b0, 3'd3, 16'h0, 26'h0, 32'h8FFF_FFFC, "R6 indirect to region end");
    step(1'b0, 3'd2, 16'h0, 26'h000_0010, 32'h0, "R5 jump uses incremented region");
    step(1'b0, 3'd5, 16'h0, 26'h0, 32'h0, "R8 illegal entry");
    step(1'b0, 3'd6, 16'h0, 26'h0, 32'h0, "R9 irq entry");
    step(1'b0, 3'd4, 16'h0, 26'h0, 32'h0, "R7 reset select");
    step(1'b0, 3'd7, 16'h0, 26'h0, 32'h0, "R10 spare acts sequential");
    step(1'b0, 3'd3, 16'h0, 26'h0, 32'hFFFF_FFFF, "R6 indirect top word");
    step(1'b0, 3'd0, 16'h0, 26'h0, 32'h0, "R3 wrap to zero");
    step(1'b0, 3'd1, 16'h8000, 26'h0, 32'h0, "R4 most negative offset");
    step(1'b1, 3'd2, 16'h0, 26'h155_5555, 32'h0, "R1 reset beats jump");
    step(1'b0, 3'd1, 16'h7FFF, 26'h0, 32'h0, "R4 most positive offset");
    step(1'b0, 3'd0, 16'h0, 26'h0, 32'h0, "R3 seq after branch");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule